// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Power-Up Wake-Up

This block keeps a 512-row asynchronous DRAM alive. After reset it holds the memory idle for a long start-up pause. It then runs a fixed number of wake-up refresh cycles, and only after those does it declare the memory ready through `init_done`. From then on an interval timer adds one owed refresh every `TICK_CYCLES` clocks. The defaults spread the full row set over an 8 ms budget, which gives roughly one refresh every 15.6 µs. Owed refreshes are counted up to a small limit. If the timer fires while the count is already at that limit, the refresh budget is taken as broken, `init_done` drops, and the wake-up burst is run again without the pause.

The block does not arbitrate the memory bus itself. It raises `ref_req` towards the access sequencer and waits for `ref_gnt`. The request is the valid and the grant is the ready. A request that is not granted stays raised, with no time limit, and every strobe stays inactive while it waits. `ref_gnt` is sampled only while no refresh cycle is running. Once a cycle has started, it runs to its end with `bus_own` high, and `ref_req` stays high until the precharge is over.

While it owns the bus, the block drives the row strobe and the byte-lane column strobes directly. A mode input chooses the cycle type. It is sampled once, when the cycle starts:
- **Column-before-row:** the memory uses its own row counter, so no address is driven.
- **Row-only:** the block drives its own row counter onto the address pins.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it: `ras_n`=1, every `cas_n` bit=1, `we_n`=1, `ref_req`=0, `bus_own`=0, `addr_en`=0 and `init_done`=0.
- R2: After reset, `ref_req` stays 0 for the first `PAUSE_CYCLES`-1 cycles and is 1 in cycle `PAUSE_CYCLES`. A grant given during the pause starts no cycle.
- R3: Exactly `WAKE_CNT` refresh cycles complete before `init_done` rises. `init_done` is seen 1 in the first cycle after the last precharge and 0 after every earlier wake-up cycle.
- R4: A refresh cycle starts only on a clock edge where `ref_req` and `ref_gnt` are both 1. While the grant is withheld, `ref_req` stays 1 with `bus_own`=0 and all strobes high. `ref_req` stays 1 for as long as `bus_own` is 1.
- R5: In a column-before-row cycle (`mode_ras_only`=0 at start), all `cas_n` bits go low together for `CSR_CYC` cycles before `ras_n` falls, then stay low for `CHR_CYC` cycles with `ras_n` low. `we_n` is 1 throughout, and the `cas_n` lanes never differ.
- R6: In every refresh cycle `ras_n` is low for exactly `RAS_CYC` cycles. A precharge of `RP_CYC` cycles follows, with all strobes high and `bus_own` still 1. Bus ownership lasts `CSR_CYC`+`RAS_CYC`+`RP_CYC` cycles for column-before-row and 1+`RAS_CYC`+`RP_CYC` cycles for row-only.
- R7: In a row-only cycle (`mode_ras_only`=1 at start), every `cas_n` bit stays 1. `addr_en` is 1 for one setup cycle plus the `RAS_CYC` low cycles, and `addr` carries the internal row counter. That counter starts at 0, advances by one after each row-only cycle, and wraps from 2^`ROW_BITS`-1 to 0.
- R8: After `init_done` rises, the first owed refresh raises `ref_req` exactly `TICK_CYCLES` cycles later. When no refresh is owed, `ref_req` is 0 after the cycle completes.
- R9: If the interval timer fires while `PEND_MAX` refreshes are already owed, `init_done` falls in that cycle (`PEND_MAX`+2 intervals after it rose when one refresh was served in between) and `ref_req` rises at once, with no pause.
- R10: Changing `mode_ras_only` during a running cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_gnt | input | 1 | Bus grant from the access sequencer (ready) |
| mode_ras_only | input | 1 | 1 selects row-only refresh, 0 selects column-before-row refresh |
| ref_req | output | 1 | Refresh bus request (valid), held until the cycle ends |
| init_done | output | 1 | Wake-up complete; host accesses allowed |
| bus_own | output | 1 | The block is driving the strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Byte-lane column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ROW_BITS | Row address for row-only refresh, 0 otherwise |
| addr_en | output | 1 | `addr` is valid and is to be driven onto the pins |

## Verification
The bench builds the block with the following parameters, so that every behaviour fits in a short run:

| Parameter | Bench value |
|---|---|
| `TICK_CYCLES` | 60 |
| `PAUSE_CYCLES` | 50 |
| `PEND_MAX` | 3 |
| `ROW_BITS` | 3 |
| `CSR_CYC` | 2 |
| `CHR_CYC` | 3 |
| `RAS_CYC` | 6 |
| `RP_CYC` | 4 |

With these values:
- The whole pause can be watched cycle by cycle.
- Overflow of the owed-refresh count comes after five intervals.
- The row counter wraps after eight row-only cycles, which the two wake-up bursts together exceed.

The short strobe phases still keep the setup, hold and precharge windows distinct from each other, so each one can be counted.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_CBR_CAS,
    CY_CBR_BOTH,
    CY_CBR_HOLD,
    CY_RO_SET,
    CY_RO_RAS,
    CY_PRE
  } cyc_state_t;

  typedef enum logic [1:0] {
    IN_PAUSE,
    IN_WAKE,
    IN_RUN
  } init_state_t;

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int TICK_CYCLES = 3900,
  parameter int PEND_MAX    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic dec_i,
  output logic pending_o,
  output logic overflow_o
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [TW-1:0] tcnt_q;
  logic [PW-1:0] pend_q;
  logic          tick;

  assign tick       = run_i && (tcnt_q == TW'(TICK_CYCLES - 1));
  assign overflow_o = tick && !dec_i && (pend_q == PW'(PEND_MAX));
  assign pending_o  = (pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else if (!run_i) begin
      tcnt_q <= '0;
      pend_q <= '0;
    end else begin
      tcnt_q <= tick ? '0 : tcnt_q + 1'b1;
      if (overflow_o)
        pend_q <= '0;
      else if (tick && !dec_i)
        pend_q <= pend_q + 1'b1;
      else if (!tick && dec_i && pend_q != '0)
        pend_q <= pend_q - 1'b1;
    end
  end

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PW'(PEND_MAX)); // R9

  AST_OVF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> !pending_o); // R9

endmodule

// File: rtl/ref_init_ctrl.sv
module ref_init_ctrl
  import refresh_pkg::*;
#(
  parameter int PAUSE_CYCLES = 25_000_000,
  parameter int WAKE_CNT     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_done_i,
  input  logic overflow_i,
  output logic pause_o,
  output logic wake_o,
  output logic run_o
);
  localparam int PCW = $clog2(PAUSE_CYCLES + 1);
  localparam int WCW = $clog2(WAKE_CNT + 1);

  init_state_t    st_q;
  logic [PCW-1:0] pcnt_q;
  logic [WCW-1:0] wcnt_q;

  assign pause_o = (st_q == IN_PAUSE);
  assign wake_o  = (st_q == IN_WAKE);
  assign run_o   = (st_q == IN_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= IN_PAUSE;
      pcnt_q <= '0;
      wcnt_q <= '0;
    end else begin
      case (st_q)
        IN_PAUSE: begin
          if (pcnt_q == PCW'(PAUSE_CYCLES - 1)) begin
            st_q   <= IN_WAKE;
            wcnt_q <= '0;
          end else begin
            pcnt_q <= pcnt_q + 1'b1;
          end
        end
        IN_WAKE: begin
          if (cyc_done_i) begin
            if (wcnt_q == WCW'(WAKE_CNT - 1))
              st_q <= IN_RUN;
            else
              wcnt_q <= wcnt_q + 1'b1;
          end
        end
        IN_RUN: begin
          if (overflow_i) begin
            st_q   <= IN_WAKE;
            wcnt_q <= '0;
          end
        end
        default: st_q <= IN_PAUSE;
      endcase
    end
  end

  AST_OVF_REWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && overflow_i) |=> wake_o); // R9

  AST_RUN_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_o) |-> $past(cyc_done_i)); // R3

endmodule

// File: rtl/ref_cycle_gen.sv
module ref_cycle_gen
  import refresh_pkg::*;
#(
  parameter int ROW_BITS = 9,
  parameter int CSR_CYC  = 2,
  parameter int CHR_CYC  = 3,
  parameter int RAS_CYC  = 13,
  parameter int RP_CYC   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                want_i,
  input  logic                gnt_i,
  input  logic                mode_ro_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                addr_en_o,
  output logic [ROW_BITS-1:0] addr_o
);
  localparam int CW = $clog2(CSR_CYC + RAS_CYC + RP_CYC + 2);

  cyc_state_t         st_q;
  logic [CW-1:0]      cnt_q;
  logic               ro_q;
  logic [ROW_BITS-1:0] row_q;
  logic               last;

  assign last      = (cnt_q == '0);
  assign busy_o    = (st_q != CY_IDLE);
  assign done_o    = (st_q == CY_PRE) && last;
  assign ras_n_o   = !(st_q == CY_CBR_BOTH || st_q == CY_CBR_HOLD || st_q == CY_RO_RAS);
  assign cas_n_o   = !(st_q == CY_CBR_CAS || st_q == CY_CBR_BOTH);
  assign addr_en_o = (st_q == CY_RO_SET) || (st_q == CY_RO_RAS);
  assign addr_o    = addr_en_o ? row_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CY_IDLE;
      cnt_q <= '0;
      ro_q  <= 1'b0;
      row_q <= '0;
    end else begin
      case (st_q)
        CY_IDLE: begin
          if (want_i && gnt_i) begin
            ro_q <= mode_ro_i;
            if (mode_ro_i) begin
              st_q  <= CY_RO_SET;
              cnt_q <= '0;
            end else begin
              st_q  <= CY_CBR_CAS;
              cnt_q <= CW'(CSR_CYC - 1);
            end
          end
        end
        CY_CBR_CAS: begin
          if (last) begin
            st_q  <= CY_CBR_BOTH;
            cnt_q <= CW'(CHR_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        CY_CBR_BOTH: begin
          if (last) begin
            st_q  <= CY_CBR_HOLD;
            cnt_q <= CW'(RAS_CYC - CHR_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        CY_CBR_HOLD: begin
          if (last) begin
            st_q  <= CY_PRE;
            cnt_q <= CW'(RP_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        CY_RO_SET: begin
          st_q  <= CY_RO_RAS;
          cnt_q <= CW'(RAS_CYC - 1);
        end
        CY_RO_RAS: begin
          if (last) begin
            st_q  <= CY_PRE;
            cnt_q <= CW'(RP_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        CY_PRE: begin
          if (last) begin
            st_q <= CY_IDLE;
            if (ro_q) row_q <= row_q + 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= CY_IDLE;
      endcase
    end
  end

  AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n_o) && !ro_q) |-> !$past(cas_n_o)); // R5

  AST_RO_CAS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ro_q) |-> cas_n_o); // R7

  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ro_q) |=> (row_q == ROW_BITS'($past(row_q) + 1'b1))); // R7

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(ro_q)); // R10

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int TICK_CYCLES  = 3900,
  parameter int PAUSE_CYCLES = 25_000_000,
  parameter int WAKE_CNT     = 8,
  parameter int PEND_MAX     = 8,
  parameter int ROW_BITS     = 9,
  parameter int CAS_LANES    = 2,
  parameter int CSR_CYC      = 2,
  parameter int CHR_CYC      = 3,
  parameter int RAS_CYC      = 13,
  parameter int RP_CYC       = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ref_gnt,
  input  logic                 mode_ras_only,
  output logic                 ref_req,
  output logic                 init_done,
  output logic                 bus_own,
  output logic                 ras_n,
  output logic [CAS_LANES-1:0] cas_n,
  output logic                 we_n,
  output logic [ROW_BITS-1:0]  addr,
  output logic                 addr_en
);
  logic in_pause, in_wake, in_run;
  logic pending, overflow;
  logic busy, done, cas_int_n, want;

  assign want      = in_wake || (in_run && pending);
  assign ref_req   = busy || want;
  assign bus_own   = busy;
  assign init_done = in_run;
  assign we_n      = 1'b1;

  ref_init_ctrl #(
    .PAUSE_CYCLES(PAUSE_CYCLES),
    .WAKE_CNT    (WAKE_CNT)
  ) u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_done_i(done),
    .overflow_i(overflow),
    .pause_o   (in_pause),
    .wake_o    (in_wake),
    .run_o     (in_run)
  );

  ref_interval_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .PEND_MAX   (PEND_MAX)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (in_run),
    .dec_i     (done && in_run),
    .pending_o (pending),
    .overflow_o(overflow)
  );

  ref_cycle_gen #(
    .ROW_BITS(ROW_BITS),
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
  ) u_cyc (
    .clk      (clk),
    .rst_n    (rst_n),
    .want_i   (want),
    .gnt_i    (ref_gnt),
    .mode_ro_i(mode_ras_only),
    .busy_o   (busy),
    .done_o   (done),
    .ras_n_o  (ras_n),
    .cas_n_o  (cas_int_n),
    .addr_en_o(addr_en),
    .addr_o   (addr)
  );

  for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
    assign cas_n[g] = cas_int_n;
  end

  AST_START_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_own) |-> ($past(ref_gnt) && $past(ref_req))); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own |-> ref_req); // R4

  AST_QUIET_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_pause |-> (!ref_req && ras_n)); // R2

endmodule

// File: tb/tb_dram_refresh_sched.sv
`timescale 1ns/1ps
module tb_dram_refresh_sched;
  localparam int TICK  = 60;
  localparam int PAUSE = 50;
  localparam int WAKE  = 8;
  localparam int PMAX  = 3;
  localparam int RB    = 3;
  localparam int LANES = 2;
  localparam int CSR   = 2;
  localparam int CHR   = 3;
  localparam int RAS   = 6;
  localparam int RP    = 4;
  localparam int ROWS  = 1 << RB;

  // fields: [5] init_done expected after cycle, [4] row-only mode, [3] flip mode mid-cycle, [2:0] grant delay
  localparam logic [5:0] VEC [0:7] = '{
    6'b0_1_0_010, 6'b0_0_1_000, 6'b0_1_1_001, 6'b0_1_0_000,
    6'b0_0_0_011, 6'b0_1_0_000, 6'b0_1_0_101, 6'b1_1_0_001
  };

  logic clk = 0, rst_n = 0, ref_gnt = 0, mode_ras_only = 0;
  logic ref_req, init_done, bus_own, ras_n, we_n, addr_en;
  logic [LANES-1:0] cas_n;
  logic [RB-1:0] addr;

  int n_chk = 0, n_fail = 0, edge_cnt = 0, exp_row = 0, t0 = 0;

  always #2 clk = ~clk;
  always @(posedge clk) if (rst_n) edge_cnt <= edge_cnt + 1;

  dram_refresh_sched #(
    .TICK_CYCLES(TICK), .PAUSE_CYCLES(PAUSE), .WAKE_CNT(WAKE), .PEND_MAX(PMAX),
    .ROW_BITS(RB), .CAS_LANES(LANES), .CSR_CYC(CSR), .CHR_CYC(CHR),
    .RAS_CYC(RAS), .RP_CYC(RP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .mode_ras_only(mode_ras_only),
    .ref_req(ref_req), .init_done(init_done), .bus_own(bus_own), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .addr_en(addr_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_edge(input int n);
    while (edge_cnt < n) step();
  endtask

  task automatic run_cycle(input bit ro, input int dly, input bit flip, input bit exp_init);
    int own = 0, lead = 0, rlow = 0, both = 0, pre = 0, aen = 0, abad = 0, wbad = 0;
    bit seen_ras = 0;
    chk(ref_req == 1'b1, "R4 request pending before grant", ref_req, 1);
    mode_ras_only = ro;
    for (int i = 0; i < dly; i++) begin
      step();
      chk(ref_req && !bus_own && ras_n && cas_n == '1, "R4 held request without grant",
          {ref_req, bus_own, ras_n}, 3'b101);
    end
    ref_gnt = 1'b1;
    step();
    while (bus_own && own < 100) begin
      own++;
      if (own == 1 && flip) mode_ras_only = !ro;
      if (!ras_n) begin
        rlow++; seen_ras = 1;
        if (cas_n == '0) both++;
      end else if (cas_n == '0 && !seen_ras) lead++;
      else if (seen_ras && cas_n == '1) pre++;
      if (addr_en) begin
        aen++;
        if (addr != RB'(exp_row)) abad++;
      end
      if (!we_n) wbad++;
      if (cas_n != '0 && cas_n != '1) wbad++;
      if (!ref_req) wbad++;
      step();
    end
    ref_gnt = 1'b0;
    chk(own == (ro ? 1 + RAS + RP : CSR + RAS + RP), "R6 ownership length", own,
        ro ? 1 + RAS + RP : CSR + RAS + RP);
    chk(rlow == RAS, "R6 row strobe width", rlow, RAS);
    chk(pre == RP, "R6 precharge length", pre, RP);
    chk(wbad == 0, "R5 we_n high, lanes equal, request held", wbad, 0);
    if (ro) begin
      chk(lead == 0 && both == 0, "R7 column strobes stay high", lead + both, 0);
      chk(aen == 1 + RAS, "R7 address drive length", aen, 1 + RAS);
      chk(abad == 0, "R7 row address value", abad, 0);
      exp_row = (exp_row + 1) % ROWS;
    end else begin
      chk(lead == CSR, "R5 column setup before row", lead, CSR);
      chk(both == CHR, "R5 column hold after row", both, CHR);
      chk(aen == 0, "R5 no address driven", aen, 0);
    end
    if (flip) chk(own == (ro ? 1 + RAS + RP : CSR + RAS + RP), "R10 mode change ignored", own,
                  ro ? 1 + RAS + RP : CSR + RAS + RP);
    chk(init_done == exp_init, "R3 init_done after cycle", init_done, exp_init);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n == '1 && we_n && !ref_req && !bus_own && !addr_en && !init_done,
        "R1 reset state", {ras_n, ref_req, bus_own, init_done}, 4'b1000);
    rst_n = 1'b1;
    ref_gnt = 1'b1;
    begin
      int early = 0;
      for (int i = 1; i < PAUSE; i++) begin
        step();
        if (i == 1)
          chk(ras_n && cas_n == '1 && !ref_req && !bus_own && !init_done, "R1 first cycle idle",
              {ras_n, ref_req, bus_own}, 3'b100);
        if (ref_req || bus_own) early++;
        if (i == PAUSE - 1) ref_gnt = 1'b0;
      end
      chk(early == 0, "R2 silent pause with grant high", early, 0);
    end
    step();
    chk(ref_req == 1'b1 && edge_cnt == PAUSE, "R2 request after pause", edge_cnt, PAUSE);

    for (int r = 0; r < 8; r++)
      run_cycle(VEC[r][4], int'(VEC[r][2:0]), VEC[r][3], VEC[r][5]);

    t0 = edge_cnt;
    wait_edge(t0 + TICK - 1);
    chk(!ref_req, "R8 no request before interval", ref_req, 0);
    step();
    chk(ref_req, "R8 request at interval", ref_req, 1);
    run_cycle(1'b1, 1, 1'b0, 1'b1);
    chk(!ref_req, "R8 request released with nothing owed", ref_req, 0);

    wait_edge(t0 + 2 * TICK + 5);
    chk(ref_req && !bus_own && ras_n && cas_n == '1, "R4 owed refresh waits for grant",
        {ref_req, bus_own}, 2'b10);
    wait_edge(t0 + (PMAX + 2) * TICK - 1);
    chk(init_done, "R9 still ready before overflow", init_done, 1);
    step();
    chk(!init_done && ref_req, "R9 overflow restarts wake-up", {init_done, ref_req}, 2'b01);
    for (int r = 0; r < WAKE; r++)
      run_cycle(1'b1, r % 2, 1'b0, r == WAKE - 1);
    chk(exp_row == (6 + 1 + WAKE) % ROWS, "R7 row counter wrapped", exp_row, (6 + 1 + WAKE) % ROWS);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule